// File: doc/BRIEF.md
# Loadable Microsecond Timestamp Counter

This block keeps a 64-bit free-running time value that advances by one on every cycle in which the microsecond tick input is high. Software sees the running value as two 32-bit words. It can preset the value through two 32-bit staging registers, one for the lower half and one for the upper half, written over a simple port that carries an index and a data word.

A preset is never applied by an ordinary write. Software first stages the lower half. It then writes the upper staging register twice: once with bit 31 set, and then with the same value and bit 31 clear. The write that clears bit 31 loads all 64 bits in a single clock edge, so the counter never holds a half-updated value.

For reading, a read strobe on the lower word latches the upper word into a shadow copy. The upper-word output then shows that copy until a read strobe on the upper word releases it. This keeps a pair of reads consistent when a carry passes between them.

Top module: `tstamp_ctr`

## Requirements
- R1: After the active-low reset is released, both count outputs read 0. Both staging registers are also 0, so a first upper write with bit 31 clear causes no reload.
- R2: When no reload takes place, the 64-bit count rises by exactly 1 at the clock edge where tick_i is 1, and holds where tick_i is 0.
- R3: When the lower word steps from 0xFFFFFFFF to 0, the upper word rises by 1 at the same edge.
- R4: A write to the lower staging register (index LO_IDX, default 4) stores the data and leaves the count unchanged.
- R5: A write to the upper staging register (index HI_IDX, default 5) with bit 31 = 0, made while the stored upper value has bit 31 = 1, reloads the count at that edge. The upper word becomes the written bits 30:0 with bit 31 forced to 0, and the lower word becomes the stored lower staging value.
- R6: An upper write with bit 31 = 1, or with bit 31 = 0 while the stored bit 31 is already 0, causes no reload.
- R7: A tick in the cycle of a reload is dropped; the count equals the loaded value after that edge.
- R8: An edge with rd_lo_i = 1 captures the upper word held before that edge. cnt_hi_o shows the captured value from then until an edge with rd_hi_i = 1 and rd_lo_i = 0; otherwise cnt_hi_o shows the live upper word. If both strobes are 1, the capture wins. cnt_lo_o always shows the live lower word.
- R9: Writes to any other index change neither the staging registers nor the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle microsecond tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | IDX_W | Register write index |
| wr_data_i | input | 32 | Register write data |
| rd_lo_i | input | 1 | Lower-word read strobe; latches the upper shadow |
| rd_hi_i | input | 1 | Upper-word read strobe; releases the shadow |
| cnt_lo_o | output | 32 | Live lower count word |
| cnt_hi_o | output | 32 | Upper count word, shadowed after a lower read |

## Verification
A tick and a reload can land on the same edge. So can a carry into the upper word and a lower-word read. The bench provokes the first case by asserting tick_i together with every arming-then-clearing upper write, and judges it by requiring the exact loaded value afterwards. It provokes the second case by presetting lower values just below the 32-bit rollover and sweeping tick spacing and read timing. After each such edge, the bench compares both output words against an arithmetic model of the count and the shadow.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CNT_W  = 2 * WORD_W;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CNT_W-1:0]  cnt_t;
endpackage

// File: rtl/tsc_wr_regs.sv
module tsc_wr_regs
  import tsc_pkg::*;
#(
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned LO_IDX = 4,
  parameter int unsigned HI_IDX = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  word_t            wr_data_i,
  output word_t            ld_lo_o,
  output logic             reload_o,
  output cnt_t             load_val_o
);
  localparam int unsigned MSB = WORD_W - 1;

  word_t ld_lo_q, ld_hi_q;
  logic  sel_lo, sel_hi;

  assign sel_lo = wr_en_i && (wr_idx_i == IDX_W'(LO_IDX));
  assign sel_hi = wr_en_i && (wr_idx_i == IDX_W'(HI_IDX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_lo_q <= '0;
      ld_hi_q <= '0;
    end else begin
      if (sel_lo) ld_lo_q <= wr_data_i;
      if (sel_hi) ld_hi_q <= wr_data_i;
    end
  end

  // falling edge of the arm bit across two upper writes
  assign reload_o   = sel_hi && !wr_data_i[MSB] && ld_hi_q[MSB];
  assign load_val_o = {1'b0, wr_data_i[MSB-1:0], ld_lo_q};
  assign ld_lo_o    = ld_lo_q;
endmodule

// File: rtl/tsc_counter.sv
module tsc_counter
  import tsc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic load_i,
  input  cnt_t load_val_i,
  output cnt_t cnt_o
);
  cnt_t cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tsc_rd_shadow.sv
module tsc_rd_shadow
  import tsc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  rd_lo_i,
  input  logic  rd_hi_i,
  input  word_t live_hi_i,
  output word_t hi_o
);
  word_t shadow_q;
  logic  held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      held_q   <= 1'b0;
    end else if (rd_lo_i) begin
      shadow_q <= live_hi_i;
      held_q   <= 1'b1;
    end else if (rd_hi_i) begin
      held_q   <= 1'b0;
    end
  end

  assign hi_o = held_q ? shadow_q : live_hi_i;
endmodule

// File: rtl/tstamp_ctr.sv
module tstamp_ctr
  import tsc_pkg::*;
#(
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned LO_IDX = 4,
  parameter int unsigned HI_IDX = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [31:0]      wr_data_i,
  input  logic             rd_lo_i,
  input  logic             rd_hi_i,
  output logic [31:0]      cnt_lo_o,
  output logic [31:0]      cnt_hi_o
);
  word_t ld_lo;
  logic  reload;
  cnt_t  load_val;
  cnt_t  cnt;

  tsc_wr_regs #(
    .IDX_W (IDX_W),
    .LO_IDX(LO_IDX),
    .HI_IDX(HI_IDX)
  ) i_wr_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .ld_lo_o   (ld_lo),
    .reload_o  (reload),
    .load_val_o(load_val)
  );

  tsc_counter i_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .load_i    (reload),
    .load_val_i(load_val),
    .cnt_o     (cnt)
  );

  tsc_rd_shadow i_rd_shadow (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_lo_i  (rd_lo_i),
    .rd_hi_i  (rd_hi_i),
    .live_hi_i(cnt[CNT_W-1:WORD_W]),
    .hi_o     (cnt_hi_o)
  );

  assign cnt_lo_o = cnt[WORD_W-1:0];
endmodule

// File: rtl/tsc_chk.sv
module tsc_chk
  import tsc_pkg::*;
#(
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned LO_IDX = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             wr_en_i,
  input logic [IDX_W-1:0] wr_idx_i,
  input word_t            wr_data_i,
  input logic             rd_lo_i,
  input word_t            cnt_hi_o,
  input logic             reload,
  input word_t            ld_lo,
  input cnt_t             cnt
);
  // R2
  a_r2_tick_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reload && tick_i) |=> (cnt == $past(cnt) + 1'b1));
  // R2
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reload && !tick_i) |=> $stable(cnt));
  // R5, R7
  a_r5_reload_val: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload |=> (cnt == $past({1'b0, wr_data_i[WORD_W-2:0], ld_lo})));
  // R4
  a_r4_lo_no_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i == IDX_W'(LO_IDX)) |-> !reload);
  // R8
  a_r8_shadow_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo_i |=> (cnt_hi_o == $past(cnt[CNT_W-1:WORD_W])));
endmodule

bind tstamp_ctr tsc_chk #(
  .IDX_W (IDX_W),
  .LO_IDX(LO_IDX)
) i_tsc_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .wr_en_i  (wr_en_i),
  .wr_idx_i (wr_idx_i),
  .wr_data_i(wr_data_i),
  .rd_lo_i  (rd_lo_i),
  .cnt_hi_o (cnt_hi_o),
  .reload   (reload),
  .ld_lo    (ld_lo),
  .cnt      (cnt)
);

// File: tb/test_tstamp_ctr.sv
`timescale 1ns/1ps
module test_tstamp_ctr;
  localparam int IDX_W = 6;
  localparam logic [IDX_W-1:0] LO = 6'd4, HI = 6'd5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, we = 0, rlo = 0, rhi = 0;
  logic [IDX_W-1:0] idx = '0;
  logic [31:0] wdata = '0, lo_o, hi_o;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [63:0] m_cnt = '0;
  logic [31:0] m_lo = '0, m_hi = '0, m_sh = '0;
  bit m_held = 0;

  always #2 clk = ~clk;

  tstamp_ctr #(.IDX_W(IDX_W)) i_tstamp_ctr (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(we),
    .wr_idx_i(idx), .wr_data_i(wdata), .rd_lo_i(rlo), .rd_hi_i(rhi),
    .cnt_lo_o(lo_o), .cnt_hi_o(hi_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model at posedge, compare after it
  task automatic cyc(string tag, bit t, bit rl, bit rh, bit w,
                     logic [IDX_W-1:0] i, logic [31:0] d);
    bit rel;
    logic [31:0] old_lo;
    @(negedge clk);
    tick = t; rlo = rl; rhi = rh; we = w; idx = i; wdata = d;
    @(posedge clk);
    rel = w && (i == HI) && !d[31] && m_hi[31];
    old_lo = m_lo;
    if (rl) begin m_sh = m_cnt[63:32]; m_held = 1; end
    else if (rh) m_held = 0;
    if (w && i == LO) m_lo = d;
    if (w && i == HI) m_hi = d;
    if (rel) m_cnt = {1'b0, d[30:0], old_lo};
    else if (t) m_cnt = m_cnt + 64'd1;
    #1;
    chk({tag, " lo"}, lo_o, m_cnt[31:0]);
    chk({tag, " hi"}, hi_o, m_held ? m_sh : m_cnt[63:32]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] hv [3];
    hv[0] = 32'h0; hv[1] = 32'h1; hv[2] = 32'h7FFF_FFFE;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset lo", lo_o, 32'h0);
    chk("R1 reset hi", hi_o, 32'h0);
    @(negedge clk); rst_n = 1;
    cyc("R1 no reload from zero hi", 0, 0, 0, 1, HI, 32'h0000_0009);
    cyc("R6 hold", 0, 0, 0, 0, '0, '0);
    cyc("R2 tick", 1, 0, 0, 0, '0, '0);
    cyc("R4 lo write only", 0, 0, 0, 1, LO, 32'h0000_1234);
    cyc("R9 other idx arm", 0, 0, 0, 1, 6'd7, 32'h8000_0055);
    cyc("R9 other idx clear", 0, 0, 0, 1, 6'd7, 32'h0000_0055);
    cyc("R6 arm no reload", 1, 0, 0, 1, HI, 32'h8000_0003);
    cyc("R6 rearm no reload", 0, 0, 0, 1, HI, 32'h8000_0004);
    cyc("R5 reload", 0, 0, 0, 1, HI, 32'h0000_0004);
    cyc("R6 second clear no reload", 1, 0, 0, 1, HI, 32'h0000_0006);
    // near-exhaustive sweep: upper presets x lower offsets x tick spacing
    for (int h = 0; h < 3; h++) begin
      for (int off = 0; off < 4; off++) begin
        for (int per = 1; per <= 3; per++) begin
          cyc("R4 stage lo", 0, 0, 0, 1, LO, 32'hFFFF_FFFF - off);
          cyc("R6 arm", 1, 0, 0, 1, HI, hv[h] | 32'h8000_0000);
          cyc("R7 reload with tick", 1, 0, 0, 1, HI, hv[h]);
          for (int c = 0; c < 10; c++) begin
            bit t = (c % per) == 0;
            bit rl = (c % 4) == 1;
            bit rh = (c % 4) == 3 || (c == 5);
            cyc(rl ? "R8 read lo" : (rh ? "R8 read hi" : "R3 carry count"),
                t, rl, rh, 0, '0, '0);
          end
          cyc("R8 release", 0, 0, 1, 0, '0, '0);
        end
      end
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule